// File: doc/BRIEF.md
# Command-to-APB Requester

This block sits on the APB side of a bridge. It accepts simple upstream commands (address, write flag, write data and byte strobes) over a valid/ready handshake and replays each one on APB as a SETUP cycle followed by one or more ACCESS cycles. The read data and the error flag from the subordinate are returned upstream on a one-cycle response pulse.

The upstream command is held unaccepted while the APB side is busy. This includes any number of wait states inserted by the subordinate. When a new command is waiting at the moment a transfer completes, the block moves directly into the SETUP cycle of the new transfer and keeps the select high, so no idle cycle appears between transfers. A single select line is driven. The protection attribute is a fixed parameter value.

Top module: `cmd_apb_requester`

## Requirements
- R1: While `rst_n` is low, `psel`, `penable` and `rsp_valid` are low, and the phase returns to idle.
- R2: A command accepted in cycle N (`req_valid` and `req_ready` high) puts the bus in SETUP in cycle N+1. In SETUP, `psel` is 1 and `penable` is 0, and `paddr`, `pwrite` and `pwdata` carry the accepted command.
- R3: The cycle after SETUP is ACCESS, with both `psel` and `penable` at 1. `penable` is never high without `psel`.
- R4: In an ACCESS cycle where `pready` is 0, the next cycle is again ACCESS. In that next cycle `paddr`, `pwrite`, `pwdata`, `pstrb` and `pprot` hold the same values.
- R5: A transfer completes in the ACCESS cycle where `pready` is 1. In the next cycle `rsp_valid` is 1 for exactly one cycle, and `rsp_rdata`/`rsp_err` equal the `prdata`/`pslverr` seen in the completion cycle. Values on those inputs during wait cycles are ignored, and `rsp_valid` is never high at any other time.
- R6: If `req_valid` is high in the completion cycle, that command is accepted in the same cycle. The next cycle is its SETUP, with `psel` still 1, `penable` at 0 and the new address.
- R7: If no command is waiting in the completion cycle, `psel` and `penable` are both 0 in the next cycle.
- R8: `pwrite` is 1 for a write and 0 for a read. For a write, `pstrb` bit i enables byte lane i (data bits 8i+7..8i) and equals the command strobe. For a read, `pstrb` is all zero.
- R9: `req_ready` is 1 only when `req_valid` is 1 and the bus is either idle or in a completing ACCESS cycle. It is never 1 in SETUP or in a waiting ACCESS cycle, whatever the value of `pready`.
- R10: `pprot` equals the parameter `PROT_VAL` whenever `psel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Upstream command present |
| req_ready | output | 1 | Command accepted this cycle |
| req_addr | input | ADDR_W | Command address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte-lane write enables |
| rsp_valid | output | 1 | Response pulse, one cycle after completion |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_err | output | 1 | Captured error flag |
| psel | output | 1 | APB select |
| penable | output | 1 | APB access phase |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| pstrb | output | DATA_W/8 | APB byte strobes |
| pprot | output | 3 | APB protection attribute |
| pready | input | 1 | Subordinate ready |
| prdata | input | DATA_W | Subordinate read data |
| pslverr | input | 1 | Subordinate error |

## Verification
Each result has a fixed due cycle:
- `req_ready` is combinational in the cycle of acceptance.
- SETUP appears one edge after acceptance, and ACCESS one edge after that.
- The response pulse appears one edge after the ACCESS cycle in which `pready` is high.

The bench model advances its phase on each rising edge, using the same inputs the design saw. It then compares every output at the following falling edge. This way every expected value is aligned to the register delay listed above. Wait cycles drive junk on `prdata` and `pslverr`, and hold `pready` high outside ACCESS, so that any sampling in the wrong cycle shows up as a mismatch.

// File: rtl/cmd_apb_pkg.sv
package cmd_apb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } apb_phase_e;

  // Next bus phase from the current one, a new acceptance and a completion.
  function automatic apb_phase_e phase_after(apb_phase_e cur, logic take, logic done);
    if (take) return PH_SETUP;
    case (cur)
      PH_SETUP:  return PH_ACCESS;
      PH_ACCESS: return done ? PH_IDLE : PH_ACCESS;
      default:   return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cmd_apb_phase_ctrl.sv
module cmd_apb_phase_ctrl
  import cmd_apb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       pready,
  output apb_phase_e phase,
  output logic       take,
  output logic       done
);

  logic slot_open;

  assign done      = (phase == PH_ACCESS) && pready;
  assign slot_open = (phase == PH_IDLE) || done;
  assign take      = req_valid && slot_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_after(phase, take, done);
  end

endmodule

// File: rtl/cmd_apb_req_hold.sv
module cmd_apb_req_hold #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_strb,
  output logic [ADDR_W-1:0]   paddr,
  output logic                pwrite,
  output logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W/8-1:0] pstrb
);

  localparam int STRB_W = DATA_W / 8;

  // Reads carry no lane enables.
  function automatic logic [STRB_W-1:0] lane_enables(logic wr, logic [STRB_W-1:0] s);
    return wr ? s : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr  <= '0;
      pwrite <= 1'b0;
      pwdata <= '0;
      pstrb  <= '0;
    end else if (take) begin
      paddr  <= req_addr;
      pwrite <= req_write;
      pwdata <= req_wdata;
      pstrb  <= lane_enables(req_write, req_strb);
    end
  end

endmodule

// File: rtl/cmd_apb_rsp_capture.sv
module cmd_apb_rsp_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_rdata <= prdata;
        rsp_err   <= pslverr;
      end
    end
  end

endmodule

// File: rtl/cmd_apb_requester.sv
module cmd_apb_requester
  import cmd_apb_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         DATA_W   = 32,
  parameter logic [2:0] PROT_VAL = 3'b000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_strb,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                psel,
  output logic                penable,
  output logic [ADDR_W-1:0]   paddr,
  output logic                pwrite,
  output logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W/8-1:0] pstrb,
  output logic [2:0]          pprot,
  input  logic                pready,
  input  logic [DATA_W-1:0]   prdata,
  input  logic                pslverr
);

  apb_phase_e phase;
  logic       take;   // command accepted this cycle
  logic       done;   // ACCESS completing this cycle

  cmd_apb_phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pready    (pready),
    .phase     (phase),
    .take      (take),
    .done      (done)
  );

  cmd_apb_req_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .req_strb  (req_strb),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pstrb     (pstrb)
  );

  cmd_apb_rsp_capture #(
    .DATA_W (DATA_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  assign req_ready = take;
  assign psel      = (phase != PH_IDLE);
  assign penable   = (phase == PH_ACCESS);
  assign pprot     = PROT_VAL;

endmodule

// File: rtl/cmd_apb_requester_chk.sv
module cmd_apb_requester_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                req_write,
  input logic [DATA_W-1:0]   req_wdata,
  input logic [DATA_W/8-1:0] req_strb,
  input logic                rsp_valid,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                rsp_err,
  input logic                psel,
  input logic                penable,
  input logic [ADDR_W-1:0]   paddr,
  input logic                pwrite,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W/8-1:0] pstrb,
  input logic [2:0]          pprot,
  input logic                pready,
  input logic [DATA_W-1:0]   prdata,
  input logic                pslverr
);

  assert_accept_to_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (psel && !penable && paddr == $past(req_addr)
      && pwrite == $past(req_write) && pwdata == $past(req_wdata)
      && pstrb == ($past(req_write) ? $past(req_strb) : '0)));

  assert_setup_to_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  assert_enable_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pwrite)
      && $stable(pwdata) && $stable(pstrb) && $stable(pprot)));

  assert_rsp_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) |=> (rsp_valid && rsp_rdata == $past(prdata)
      && rsp_err == $past(pslverr)));

  assert_rsp_only_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(psel && penable && pready));

  assert_done_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && !req_valid) |=> (!psel && !penable));

  assert_read_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> (pstrb == '0));

  assert_ready_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (req_valid && (!psel || (penable && pready))));

endmodule

bind cmd_apb_requester cmd_apb_requester_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/cmd_apb_requester_test.sv
`timescale 1ns/1ps
module cmd_apb_requester_test;

  localparam int         AW   = 12;
  localparam int         DW   = 32;
  localparam int         SW   = DW / 8;
  localparam logic [2:0] PROT = 3'b010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [SW-1:0] req_strb = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [SW-1:0] pstrb;
  logic [2:0]    pprot;
  logic          pready = 1'b0;
  logic [DW-1:0] prdata = '0;
  logic          pslverr = 1'b0;

  always #2 clk = ~clk;

  cmd_apb_requester #(.ADDR_W(AW), .DATA_W(DW), .PROT_VAL(PROT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
    .pstrb(pstrb), .pprot(pprot), .pready(pready), .prdata(prdata), .pslverr(pslverr));

  typedef struct {
    logic [AW-1:0] a;
    logic          w;
    logic [DW-1:0] d;
    logic [SW-1:0] s;
    int            waits;
    logic          err;
    int            gap;
  } cmd_t;

  cmd_t   cmds[$];
  integer checks = 0;
  integer fails  = 0;

  // model state
  int            m_ph = 0;         // 0 idle, 1 setup, 2 access
  logic [AW-1:0] m_addr;
  logic          m_write;
  logic [DW-1:0] m_wdata;
  logic [SW-1:0] m_strb;
  logic          m_rsp_v = 1'b0;
  logic [DW-1:0] m_rsp_d = '0;
  logic          m_rsp_e = 1'b0;
  logic          m_b2b = 1'b0, m_wait = 1'b0, acc_last = 1'b0;
  int            cur_waits = 0, wcnt = 0, idx = 0, gap_cnt = 0;
  logic          cur_err = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_pat(input logic [AW-1:0] a);
    return 32'h1357_9BDF ^ {a, a[7:0], a};
  endfunction

  task automatic push(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                      input logic [SW-1:0] s, input int wt, input logic e, input int g);
    cmd_t c;
    c.a = a; c.w = w; c.d = d; c.s = s; c.waits = wt; c.err = e; c.gap = g;
    cmds.push_back(c);
  endtask

  task automatic model_edge();
    logic done, acc;
    done = (m_ph == 2) && pready;
    acc  = req_valid && (m_ph == 0 || done);
    m_rsp_v = done;
    if (done) begin m_rsp_d = prdata; m_rsp_e = pslverr; end
    m_b2b  = acc && done;
    m_wait = (m_ph == 2) && !done && !acc;
    if (acc) begin
      m_addr = req_addr; m_write = req_write; m_wdata = req_wdata;
      m_strb = req_write ? req_strb : '0;
      cur_waits = cmds[idx].waits; cur_err = cmds[idx].err;
      m_ph = 1;
    end else if (m_ph == 1) begin
      m_ph = 2; wcnt = cur_waits;
    end else if (done) begin
      m_ph = 0;
    end
    acc_last = acc;
  endtask

  task automatic drive();
    if (acc_last) begin
      idx++;
      req_valid = 1'b0;
      gap_cnt = (idx < cmds.size()) ? cmds[idx].gap : 0;
    end
    if (!req_valid && idx < cmds.size()) begin
      if (gap_cnt == 0) begin
        req_valid = 1'b1;
        req_addr  = cmds[idx].a; req_write = cmds[idx].w;
        req_wdata = cmds[idx].d; req_strb  = cmds[idx].s;
      end else gap_cnt--;
    end
    if (m_ph == 2) begin
      if (wcnt > 0) begin
        pready = 1'b0; prdata = 32'hDEAD_0000 | DW'(wcnt); pslverr = 1'b1; wcnt--;
      end else begin
        pready = 1'b1; prdata = rd_pat(m_addr); pslverr = cur_err;
      end
    end else begin
      pready = 1'b1; prdata = 32'hBAD0_0BAD; pslverr = 1'b1;   // ignored outside ACCESS
    end
  endtask

  task automatic compare();
    string tp;
    logic  exp_rdy;
    if (m_ph == 0)      tp = "R7";
    else if (m_ph == 1) tp = m_b2b ? "R6" : "R2";
    else                tp = m_wait ? "R4" : "R3";
    chk(tp, "psel", 64'(psel), 64'(m_ph != 0));
    chk(tp, "penable", 64'(penable), 64'(m_ph == 2));
    if (m_ph != 0) begin
      chk(tp, "paddr", 64'(paddr), 64'(m_addr));
      chk(tp, "pwdata", 64'(pwdata), 64'(m_wdata));
      chk("R8", "pwrite", 64'(pwrite), 64'(m_write));
      chk("R8", "pstrb", 64'(pstrb), 64'(m_strb));
      chk("R10", "pprot", 64'(pprot), 64'(PROT));
    end
    exp_rdy = req_valid && (m_ph == 0 || (m_ph == 2 && pready));
    chk("R9", "req_ready", 64'(req_ready), 64'(exp_rdy));
    chk("R5", "rsp_valid", 64'(rsp_valid), 64'(m_rsp_v));
    if (m_rsp_v) begin
      chk("R5", "rsp_rdata", 64'(rsp_rdata), 64'(m_rsp_d));
      chk("R5", "rsp_err", 64'(rsp_err), 64'(m_rsp_e));
    end
  endtask

  initial begin
    int cyc;
    int tail;
    push(12'h010, 1'b1, 32'hA1B2_C3D4, 4'hF,    0, 1'b0, 2);
    push(12'h020, 1'b0, 32'h0,         4'hF,    0, 1'b0, 0);
    push(12'h034, 1'b1, 32'h5566_7788, 4'b0101, 3, 1'b0, 0);
    push(12'h048, 1'b0, 32'h0,         4'hF,    1, 1'b1, 0);
    push(12'h05C, 1'b1, 32'h0F0F_F0F0, 4'b0011, 0, 1'b1, 3);
    push(12'h0A0, 1'b0, 32'h0,         4'h0,    5, 1'b0, 1);
    push(12'hFFC, 1'b1, 32'hFFFF_0001, 4'b1000, 2, 1'b0, 0);
    push(12'h000, 1'b0, 32'h0,         4'hF,    0, 1'b0, 0);
    for (int i = 0; i < 12; i++)
      push(AW'(i * 37), i[0], DW'(32'h9E37_79B9 * (i + 1)), SW'(i * 3 + 1),
           i % 4, (i % 5) == 3, (i % 3 == 0) ? 1 : 0);
    gap_cnt = cmds[0].gap;

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "psel in reset", 64'(psel), 64'd0);
    chk("R1", "penable in reset", 64'(penable), 64'd0);
    chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1", "req_ready in reset", 64'(req_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive();
    #1 compare();

    cyc = 0;
    tail = 0;
    forever begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      drive();
      #1 compare();
      cyc++;
      if (idx >= cmds.size() && m_ph == 0 && !m_rsp_v) tail++;
      if (tail > 4) break;
      if (cyc > 5000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        break;
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule